// File: doc/BRIEF.md
# HD Sync Waveform Inserter

This block overwrites samples of a three-channel HD video stream with levels taken from tables that software loads. Three linked tables describe a frame. A sequence table lists line kinds and how many times each one repeats. A line-kind table gives eight ordered pointers into a segment table. Each segment entry holds four (length, level-select) pairs, and the level-select picks a 10-bit level from a small level table. A segment can mark its level as luma-only. In that case only the Y/green channel is replaced and both chroma channels pass through.

Software loads the tables one byte at a time. It first writes a start address with a table select, and then streams data bytes that land at successive addresses. A frame-start pulse restarts the walk at the first sequence entry. The walk then advances by one pixel per clock. Zero pointers, zero lengths and zero repeat counts are skipped without costing a clock. When the last used sequence entry has run out, the block passes video through untouched until the next frame start.

Top module: `hd_sync_inserter`

## Requirements
- R1: While reset is asserted, and at the first sample after it, `out_y`, `out_cb` and `out_cr` are 0 and `out_ins` is 0. Reset clears every table byte.
- R2: A write with `cfg_is_addr`=1 selects the table (`cfg_tbl`: 0 sequence, 1 line kind, 2 segment, 3 level) and sets the byte pointer to `cfg_data[5:0]`. Each following data write stores `cfg_data` at the pointer and then increments the pointer. Sequence entry e takes byte 2e as repeat[7:0], and byte 2e+1 carries the line-kind pointer in bits 7:4 and repeat[9:8] in bits 1:0. Line kind k (pointer value k) uses bytes 4(k-1)..4(k-1)+3. Pointer p sits in byte p/2, at bits 2:0 for even p and bits 6:4 for odd p. Segment s (pointer value s) has pair q at bytes 8(s-1)+2q (length) and 8(s-1)+2q+1 (level-select). Level i is formed from byte 2i (bits 7:0) and bits 1:0 of byte 2i+1 (bits 9:8).
- R3: The byte pointer stops at 63 and never wraps. Data writes at addresses past the end of the selected table (30, 60, 56 and 32 bytes) change nothing.
- R4: A pair with length L, where L is nonzero, drives its level for exactly L+1 consecutive pixels. A pair with L=0 is skipped and takes no pixel.
- R5: Segment pointers are used in order 0 to 7, and the pairs in each segment in order 0 to 3. A pointer of 0 is skipped, and a nonzero pointer s selects segment s.
- R6: A sequence entry with repeat count N, where N is nonzero, and a nonzero line-kind pointer plays that line kind N times. An entry with a zero count or a zero pointer is skipped and takes no pixel.
- R7: Level-select bits 3:0 pick the level. When bit 7 is 1, only `out_y` takes the level and `out_cb`/`out_cr` carry the input. Otherwise all three channels take the level.
- R8: A played line whose pointers and pairs are all unused takes one pixel, and that pixel passes through.
- R9: After the last used sequence entry, and before any frame start, every output equals its input delayed by one clock and `out_ins` is 0.
- R10: A frame-start pulse sampled at any time restarts the walk. The pixel after the pulse is the first pixel of the first used sequence entry.
- R11: Outputs are registered. A pixel presented in one cycle appears, replaced or passed through, after the next clock edge, and `out_ins` is 1 exactly when a level replaced it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Byte write strobe |
| cfg_is_addr | input | 1 | 1: the byte is a start address, 0: the byte is table data |
| cfg_tbl | input | 2 | Table select, used on address writes |
| cfg_data | input | 8 | Address or data byte |
| frame_start | input | 1 | Restarts the table walk |
| vid_y | input | 10 | Input Y/green sample |
| vid_cb | input | 10 | Input Cb/blue sample |
| vid_cr | input | 10 | Input Cr/red sample |
| out_y | output | 10 | Output Y/green sample |
| out_cb | output | 10 | Output Cb/blue sample |
| out_cr | output | 10 | Output Cr/red sample |
| out_ins | output | 1 | Output sample carries an inserted level |

## Verification
On every cycle, the assertions check the per-pixel rules. These are: pass-through timing when nothing is inserted, equal levels on all channels for full insertion, untouched chroma for luma-only insertion, length countdown with a stable slot, a nonzero remaining repeat count while walking, and a restart after a frame start that finds a used entry. Only the bench scenarios can show that the whole pixel sequence is right. That covers table layout, pointer order, skip rules that take no pixel, ten-bit repeat counts, one-pixel empty lines, and pointer saturation. To show it, the bench expands the loaded tables into a per-pixel stream and compares each output pixel against it.

// File: rtl/hsi_pkg.sv
package hsi_pkg;
  localparam int LC_N       = 15;
  localparam int LT_N       = 15;
  localparam int PAT_N      = 7;
  localparam int PAIRS      = 4;
  localparam int PTRS       = 8;
  localparam int LVL_N      = 16;
  localparam int PIX_W      = 10;
  localparam int CNT_W      = 10;
  localparam int ADDR_W     = 6;
  localparam int SLOTS      = PTRS * PAIRS;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int LC_W       = $clog2(LC_N + 1);
  localparam int LT_WORD_W  = PTRS * 4;
  localparam int CNT_BYTES  = 2 * LC_N;
  localparam int TYP_BYTES  = (PTRS / 2) * LT_N;
  localparam int PAT_BYTES  = 2 * PAIRS * PAT_N;
  localparam int LVL_BYTES  = 2 * LVL_N;
  localparam int CNT_MW     = CNT_BYTES * 8;
  localparam int TYP_MW     = TYP_BYTES * 8;
  localparam int PAT_MW     = PAT_BYTES * 8;
  localparam int LVL_MW     = LVL_BYTES * 8;

  typedef enum logic [1:0] {TBL_SEQ = 2'd0, TBL_KIND = 2'd1, TBL_SEG = 2'd2, TBL_LVL = 2'd3} tbl_e;

  typedef struct packed {
    logic              found;
    logic [SLOT_W-1:0] idx;
  } hit_t;

  // Lowest set bit at or above start.
  function automatic hit_t find_from(logic [SLOTS-1:0] v, int start);
    hit_t h;
    h = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (v[i] && i >= start) begin
        h.found = 1'b1;
        h.idx   = SLOT_W'(i);
      end
    return h;
  endfunction

  function automatic logic [CNT_W-1:0] seq_count(logic [CNT_MW-1:0] m, int e);
    return {m[(2*e+1)*8 +: 2], m[(2*e)*8 +: 8]};
  endfunction

  function automatic logic [3:0] seq_kind(logic [CNT_MW-1:0] m, int e);
    return m[(2*e+1)*8+4 +: 4];
  endfunction

  function automatic logic [LT_WORD_W-1:0] kind_word(logic [TYP_MW-1:0] m, logic [3:0] k);
    if (k == 4'd0) return '0;
    return m[(int'(k)-1)*LT_WORD_W +: LT_WORD_W];
  endfunction

  // which = 0: length byte, which = 1: level-select byte.
  function automatic logic [7:0] slot_byte(logic [LT_WORD_W-1:0] word, logic [PAT_MW-1:0] seg,
                                           int slot, int which);
    int p;
    int q;
    logic [2:0] ptr;
    p   = slot / PAIRS;
    q   = slot % PAIRS;
    ptr = word[(p/2)*8 + (p%2)*4 +: 3];
    if (ptr == 3'd0) return 8'd0;
    return seg[((int'(ptr)-1)*2*PAIRS + q*2 + which)*8 +: 8];
  endfunction

  function automatic logic [PIX_W-1:0] level_of(logic [LVL_MW-1:0] m, logic [3:0] i);
    return {m[(2*int'(i)+1)*8 +: 2], m[(2*int'(i))*8 +: 8]};
  endfunction
endpackage

// File: rtl/hsi_tables.sv
module hsi_tables
  import hsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_is_addr,
  input  logic [1:0]        cfg_tbl,
  input  logic [7:0]        cfg_data,
  output logic [CNT_MW-1:0] seq_mem,
  output logic [TYP_MW-1:0] kind_mem,
  output logic [PAT_MW-1:0] seg_mem,
  output logic [LVL_MW-1:0] lvl_mem
);
  localparam logic [ADDR_W-1:0] PTR_MAX = '1;

  tbl_e              sel_q;
  logic [ADDR_W-1:0] ptr_q;
  int                base;

  assign base = int'(ptr_q) * 8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= TBL_SEQ;
      ptr_q    <= '0;
      seq_mem  <= '0;
      kind_mem <= '0;
      seg_mem  <= '0;
      lvl_mem  <= '0;
    end else if (cfg_we) begin
      if (cfg_is_addr) begin
        sel_q <= tbl_e'(cfg_tbl);
        ptr_q <= cfg_data[ADDR_W-1:0];
      end else begin
        case (sel_q)
          TBL_SEQ:  if (int'(ptr_q) < CNT_BYTES) seq_mem[base +: 8]  <= cfg_data;
          TBL_KIND: if (int'(ptr_q) < TYP_BYTES) kind_mem[base +: 8] <= cfg_data;
          TBL_SEG:  if (int'(ptr_q) < PAT_BYTES) seg_mem[base +: 8]  <= cfg_data;
          default:  if (int'(ptr_q) < LVL_BYTES) lvl_mem[base +: 8]  <= cfg_data;
        endcase
        if (ptr_q != PTR_MAX) ptr_q <= ptr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hsi_slot_scan.sv
module hsi_slot_scan
  import hsi_pkg::*;
(
  input  logic [LT_WORD_W-1:0] kind_word_i,
  input  logic [PAT_MW-1:0]    seg_mem,
  output logic [SLOTS-1:0]     slot_used
);
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_used[s] = slot_byte(kind_word_i, seg_mem, s, 0) != 8'd0;
  end
endmodule

// File: rtl/hd_sync_inserter.sv
module hd_sync_inserter
  import hsi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_is_addr,
  input  logic [1:0]       cfg_tbl,
  input  logic [7:0]       cfg_data,
  input  logic             frame_start,
  input  logic [PIX_W-1:0] vid_y,
  input  logic [PIX_W-1:0] vid_cb,
  input  logic [PIX_W-1:0] vid_cr,
  output logic [PIX_W-1:0] out_y,
  output logic [PIX_W-1:0] out_cb,
  output logic [PIX_W-1:0] out_cr,
  output logic             out_ins
);
  logic [CNT_MW-1:0] seq_mem;
  logic [TYP_MW-1:0] kind_mem;
  logic [PAT_MW-1:0] seg_mem;
  logic [LVL_MW-1:0] lvl_mem;

  hsi_tables u_tables (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_is_addr(cfg_is_addr),
    .cfg_tbl(cfg_tbl), .cfg_data(cfg_data), .seq_mem(seq_mem),
    .kind_mem(kind_mem), .seg_mem(seg_mem), .lvl_mem(lvl_mem)
  );

  // Walk state
  logic              active, cur_empty;
  logic [LC_W-1:0]   lc_idx;
  logic [CNT_W-1:0]  lc_left;
  logic [SLOT_W-1:0] cur_slot;
  logic [7:0]        dur_left;
  logic              luma_q;

  // Which sequence entries are usable
  logic [SLOTS-1:0] seq_used;
  for (genvar e = 0; e < SLOTS; e++) begin : g_used
    if (e < LC_N) begin : g_real
      assign seq_used[e] = (seq_count(seq_mem, e) != '0) && (seq_kind(seq_mem, e) != 4'd0);
    end else begin : g_pad
      assign seq_used[e] = 1'b0;
    end
  end

  hit_t                 ent_hit, line_hit, line_first, nxt_first;
  logic [LT_WORD_W-1:0] cur_word, nxt_word;
  logic [SLOTS-1:0]     vld_cur, vld_nxt;
  logic                 start_hit;

  assign ent_hit   = find_from(seq_used, frame_start ? 0 : int'(lc_idx) + 1);
  assign start_hit = frame_start && ent_hit.found;
  assign cur_word  = kind_word(kind_mem, seq_kind(seq_mem, int'(lc_idx)));
  assign nxt_word  = kind_word(kind_mem, seq_kind(seq_mem, int'(ent_hit.idx)));

  hsi_slot_scan u_scan_cur (.kind_word_i(cur_word), .seg_mem(seg_mem), .slot_used(vld_cur));
  hsi_slot_scan u_scan_nxt (.kind_word_i(nxt_word), .seg_mem(seg_mem), .slot_used(vld_nxt));

  assign line_hit   = find_from(vld_cur, int'(cur_slot) + 1);
  assign line_first = find_from(vld_cur, 0);
  assign nxt_first  = find_from(vld_nxt, 0);

  logic              n_active, n_empty, take_entry;
  logic [LC_W-1:0]   n_idx;
  logic [CNT_W-1:0]  n_left;
  logic [SLOT_W-1:0] n_slot;
  logic [7:0]        n_dur;

  always_comb begin
    n_active   = active;
    n_empty    = cur_empty;
    n_idx      = lc_idx;
    n_left     = lc_left;
    n_slot     = cur_slot;
    n_dur      = dur_left;
    take_entry = 1'b0;
    if (frame_start) begin
      take_entry = 1'b1;
    end else if (active) begin
      if (!cur_empty && dur_left != 8'd0) begin
        n_dur = dur_left - 8'd1;
      end else if (line_hit.found) begin
        n_slot = line_hit.idx;
        n_dur  = slot_byte(cur_word, seg_mem, int'(line_hit.idx), 0);
      end else if (lc_left > CNT_W'(1)) begin
        n_left  = lc_left - 1'b1;
        n_empty = !line_first.found;
        n_slot  = line_first.idx;
        n_dur   = line_first.found ? slot_byte(cur_word, seg_mem, int'(line_first.idx), 0) : 8'd0;
      end else begin
        take_entry = 1'b1;
      end
    end
    if (take_entry) begin
      n_active = ent_hit.found;
      n_idx    = LC_W'(ent_hit.idx);
      n_left   = seq_count(seq_mem, int'(ent_hit.idx));
      n_empty  = !nxt_first.found;
      n_slot   = nxt_first.idx;
      n_dur    = nxt_first.found ? slot_byte(nxt_word, seg_mem, int'(nxt_first.idx), 0) : 8'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cur_empty <= 1'b1;
      lc_idx    <= '0;
      lc_left   <= '0;
      cur_slot  <= '0;
      dur_left  <= '0;
    end else begin
      active    <= n_active;
      cur_empty <= n_empty;
      lc_idx    <= n_idx;
      lc_left   <= n_left;
      cur_slot  <= n_slot;
      dur_left  <= n_dur;
    end
  end

  // Insertion and output stage
  logic             ins_now;
  logic [7:0]       sel_byte;
  logic [PIX_W-1:0] level;
  assign ins_now  = active && !cur_empty;
  assign sel_byte = slot_byte(cur_word, seg_mem, int'(cur_slot), 1);
  assign level    = level_of(lvl_mem, sel_byte[3:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_y   <= '0;
      out_cb  <= '0;
      out_cr  <= '0;
      out_ins <= 1'b0;
      luma_q  <= 1'b0;
    end else begin
      out_y   <= ins_now ? level : vid_y;
      out_cb  <= (ins_now && !sel_byte[7]) ? level : vid_cb;
      out_cr  <= (ins_now && !sel_byte[7]) ? level : vid_cr;
      out_ins <= ins_now;
      luma_q  <= ins_now && sel_byte[7];
    end
  end
endmodule

// File: rtl/hsi_check.sv
module hsi_check
  import hsi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic [PIX_W-1:0]  vid_y,
  input logic [PIX_W-1:0]  vid_cb,
  input logic [PIX_W-1:0]  vid_cr,
  input logic [PIX_W-1:0]  out_y,
  input logic [PIX_W-1:0]  out_cb,
  input logic [PIX_W-1:0]  out_cr,
  input logic              out_ins,
  input logic              luma_q,
  input logic              active,
  input logic              cur_empty,
  input logic [7:0]        dur_left,
  input logic [SLOT_W-1:0] cur_slot,
  input logic [CNT_W-1:0]  lc_left,
  input logic              start_hit
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !out_ins |-> out_y == $past(vid_y) && out_cb == $past(vid_cb) && out_cr == $past(vid_cr)); // R11
  AST_FULL_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_ins && !luma_q |-> out_y == out_cb && out_cb == out_cr); // R7
  AST_LUMA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && luma_q |-> out_cb == $past(vid_cb) && out_cr == $past(vid_cr)); // R7
  AST_DUR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    active && !cur_empty && dur_left != 8'd0 && !frame_start
      |=> dur_left == $past(dur_left) - 8'd1 && $stable(cur_slot)); // R4
  AST_REPEAT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> lc_left != '0); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(active) |-> !out_ins); // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> active); // R10
endmodule

bind hd_sync_inserter hsi_check u_hsi_check (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .vid_y(vid_y), .vid_cb(vid_cb), .vid_cr(vid_cr),
  .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr), .out_ins(out_ins),
  .luma_q(luma_q), .active(active), .cur_empty(cur_empty), .dur_left(dur_left),
  .cur_slot(cur_slot), .lc_left(lc_left), .start_hit(start_hit)
);

// File: tb/hd_sync_inserter_bench.sv
module hd_sync_inserter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_is_addr = 1'b0;
  logic [1:0] cfg_tbl = 2'd0;
  logic [7:0] cfg_data = 8'd0;
  logic       frame_start = 1'b0;
  logic [9:0] vid_y = 10'd0, vid_cb = 10'd0, vid_cr = 10'd0;
  logic [9:0] out_y, out_cb, out_cr;
  logic       out_ins;

  always #4 clk = ~clk;

  hd_sync_inserter u_hd_sync_inserter (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_is_addr(cfg_is_addr),
    .cfg_tbl(cfg_tbl), .cfg_data(cfg_data), .frame_start(frame_start),
    .vid_y(vid_y), .vid_cb(vid_cb), .vid_cr(vid_cr),
    .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr), .out_ins(out_ins)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // Bench mirror of the tables
  int m_seq[30], m_kind[60], m_seg[56], m_lvl[32];
  int m_sel = 0, m_ptr = 0;

  int  st_lvl[1024];
  bit  st_ins[1024], st_luma[1024];
  int  st_len;

  task automatic cfg_addr(int t, int a);
    @(negedge clk);
    cfg_we = 1; cfg_is_addr = 1; cfg_tbl = 2'(t); cfg_data = 8'(a);
    m_sel = t; m_ptr = a;
  endtask

  task automatic cfg_put(int b);
    @(negedge clk);
    cfg_we = 1; cfg_is_addr = 0; cfg_data = 8'(b);
    case (m_sel)
      0: if (m_ptr < 30) m_seq[m_ptr] = b & 255;
      1: if (m_ptr < 60) m_kind[m_ptr] = b & 255;
      2: if (m_ptr < 56) m_seg[m_ptr] = b & 255;
      default: if (m_ptr < 32) m_lvl[m_ptr] = b & 255;
    endcase
    if (m_ptr < 63) m_ptr++;
  endtask

  task automatic cfg_idle();
    @(negedge clk);
    cfg_we = 0; cfg_is_addr = 0;
  endtask

  function automatic void push(bit ins, int lv, bit lu);
    if (st_len < 1024) begin
      st_ins[st_len] = ins; st_lvl[st_len] = lv; st_luma[st_len] = lu; st_len++;
    end
  endfunction

  // Expand tables into a per-pixel stream
  function automatic void expand();
    st_len = 0;
    for (int e = 0; e < 15; e++) begin
      int c = m_seq[2*e] + 256 * (m_seq[2*e+1] % 4);
      int k = m_seq[2*e+1] / 16;
      if (c != 0 && k != 0)
        for (int r = 0; r < c; r++) begin
          bit any = 0;
          for (int p = 0; p < 8; p++) begin
            int pb = m_kind[4*(k-1) + p/2];
            int s  = ((p % 2) ? (pb / 16) : pb) % 8;
            if (s != 0)
              for (int q = 0; q < 4; q++) begin
                int d = m_seg[8*(s-1) + 2*q];
                int v = m_seg[8*(s-1) + 2*q + 1];
                int li = v % 16;
                if (d != 0)
                  for (int n = 0; n <= d; n++) begin
                    push(1, m_lvl[2*li] + 256 * (m_lvl[2*li+1] % 4), (v / 128) % 2 == 1);
                    any = 1;
                  end
              end
          end
          if (!any) push(0, 0, 0);
        end
    end
  endfunction

  function automatic int fy(int k);  return (k * 7 + 3) % 1024;    endfunction
  function automatic int fcb(int k); return (k * 13 + 100) % 1024; endfunction
  function automatic int fcr(int k); return (k * 29 + 500) % 1024; endfunction

  // Play n pixels after a frame start; optional restart at pixel rs (-1: none)
  task automatic run_walk(int n, int rs, string tag);
    int idx = 0;
    int ey = 0, ecb = 0, ecr = 0;
    bit ei = 0;
    expand();
    @(negedge clk);
    frame_start = 1;
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k > 0) begin
        n_tests++;
        if (out_y !== 10'(ey) || out_cb !== 10'(ecb) || out_cr !== 10'(ecr) || out_ins !== ei) begin
          n_fail++;
          $display("FAIL %s pixel %0d: y/cb/cr/ins = %0d/%0d/%0d/%0b expected %0d/%0d/%0d/%0b",
                   tag, k - 1, out_y, out_cb, out_cr, out_ins, ey, ecb, ecr, ei);
        end
      end
      frame_start = (k == rs);
      vid_y = 10'(fy(k)); vid_cb = 10'(fcb(k)); vid_cr = 10'(fcr(k));
      if (idx < st_len && st_ins[idx]) begin
        ei = 1; ey = st_lvl[idx];
        ecb = st_luma[idx] ? fcb(k) : st_lvl[idx];
        ecr = st_luma[idx] ? fcr(k) : st_lvl[idx];
      end else begin
        ei = 0; ey = fy(k); ecb = fcb(k); ecr = fcr(k);
      end
      idx = (k == rs) ? 0 : idx + 1;
    end
    frame_start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    foreach (m_seq[i]) m_seq[i] = 0;
    foreach (m_kind[i]) m_kind[i] = 0;
    foreach (m_seg[i]) m_seg[i] = 0;
    foreach (m_lvl[i]) m_lvl[i] = 0;
    vid_y = 10'd111; vid_cb = 10'd222; vid_cr = 10'd333;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_tests++;
    if (out_y !== 0 || out_cb !== 0 || out_cr !== 0 || out_ins !== 0) begin
      n_fail++;
      $display("FAIL R1 reset: y/cb/cr/ins = %0d/%0d/%0d/%0b expected 0/0/0/0", out_y, out_cb, out_cr, out_ins);
    end
    rst_n = 1;
    n_tests++;
    if (out_y !== 0 || out_ins !== 0) begin
      n_fail++;
      $display("FAIL R1 first sample: y/ins = %0d/%0b expected 0/0", out_y, out_ins);
    end

    // R9: empty tables, pure pass-through
    run_walk(20, -1, "R9");

    // R2 layout: levels i*61+5
    cfg_addr(3, 0);
    for (int i = 0; i < 16; i++) begin cfg_put((i*61+5) % 256); cfg_put((i*61+5) / 256); end
    // Segments: 1 = {(2,lvl1),(0),(0),(1,lvl2 luma)}, 2 = {(0),(3,lvl0)}, 3 = all unused
    cfg_addr(2, 0);
    cfg_put(2); cfg_put(8'h01); cfg_put(0); cfg_put(8'h05); cfg_put(0); cfg_put(0); cfg_put(1); cfg_put(8'h82);
    cfg_put(0); cfg_put(0); cfg_put(3); cfg_put(8'h00); cfg_put(0); cfg_put(0); cfg_put(0); cfg_put(0);
    for (int i = 0; i < 8; i++) cfg_put(0);
    // Line kinds: 1 = ptrs {1,0,2}, 2 = ptr6=1, ptr7=2, 3 = ptr0=3 (empty line)
    cfg_addr(1, 0);
    cfg_put(8'h01); cfg_put(8'h02); cfg_put(0); cfg_put(0);
    cfg_put(0); cfg_put(0); cfg_put(0); cfg_put(8'h21);
    cfg_put(8'h03); cfg_put(0); cfg_put(0); cfg_put(0);
    // Sequence: (2,k1) (5,k0 skip) (0,k2 skip) (1,k2) (2,k3 empty) (1,k1)
    cfg_addr(0, 0);
    cfg_put(2); cfg_put(8'h10); cfg_put(5); cfg_put(8'h00); cfg_put(0); cfg_put(8'h20);
    cfg_put(1); cfg_put(8'h20); cfg_put(2); cfg_put(8'h30); cfg_put(1); cfg_put(8'h10);
    cfg_idle();
    run_walk(60, -1, "R2 R4 R5 R6 R7 R8 R11");

    // R10: restart in the middle of the walk
    run_walk(40, 12, "R10");

    // R6: ten-bit repeat count (258 lines of kind 4 = segment 4, one 2-pixel pair)
    cfg_addr(2, 24); cfg_put(1); cfg_put(8'h03);
    cfg_addr(1, 12); cfg_put(8'h04);
    cfg_addr(0, 0);
    cfg_put(8'h02); cfg_put(8'h41); cfg_put(1); cfg_put(8'h10);
    for (int i = 4; i < 30; i++) cfg_put(0);
    cfg_idle();
    run_walk(540, -1, "R6 repeat bits");

    // R3: pointer saturates at 63, bytes past the level table are dropped
    cfg_addr(3, 30); cfg_put(8'hAA); cfg_put(8'h02);
    for (int i = 0; i < 40; i++) cfg_put(8'hFF);
    cfg_idle();
    run_walk(540, -1, "R3");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule